// File: doc/BRIEF.md
# Bus-master channel status and pointer registers

This block is the host-visible register slice of a single storage bus-master channel. It keeps a status byte, a byte that device-specific software may use freely, and a 32-bit descriptor table pointer held as four bytes. The host reaches every byte through one byte-wide port. The port takes an offset, a write strobe and write data, and returns read data for the addressed offset.

Each status bit has its own owners. A static strap drives the simplex-capability bit. The two drive DMA-capable bits are plain host storage. The interrupt flag is set on a rising edge of the interrupt-logic input. The error flag is set by a firmware strobe. The host clears both of those flags by writing a one. The active flag is set by a rising edge of the start bus-master input. Only a firmware strobe clears it, so host writes cannot disturb it. In every case, a set event that lands in the same cycle as a clear takes priority.

Top module: `dma_status_regs`

## Requirements
- R1: After reset the status byte at offset 2 reads 0x00 with bit 7 taken from the simplex strap (0x80 with the strap high). Offset 3 and offsets 4 to 7 read 0x00.
- R2: Status bit 7 always equals `simplex_cfg_i`, and host writes to it have no effect.
- R3: Status bits 6 and 5 take host write data bits 6 and 5 on a write to offset 2. Status bits 4 and 3 always read 0, whatever is written.
- R4: Status bit 2 is set on the clock edge at which `irq_i` is sampled high after having been sampled low. A level held high sets it only once. A host write to offset 2 with data bit 2 at 1 clears it, and a rising edge in that same cycle wins over the clear.
- R5: Status bit 1 is set on the edge at which `fw_err_set_i` is high. A host write to offset 2 with data bit 1 at 1 clears it, and a set in that same cycle wins.
- R6: Status bit 0 is set on the edge at which `start_i` is sampled high after having been sampled low. Only `fw_act_clr_i` clears it, and host writes of any value leave it unchanged. A rising start edge in the same cycle as the firmware clear leaves it set.
- R7: Offset 3 is a host read/write byte.
- R8: Offsets 4, 5, 6 and 7 hold descriptor pointer bytes 0 (least significant) to 3. Each is host read/write, and the pointer changes only on a host write.
- R9: Read data is combinational from `host_addr_i` and reflects state in the same cycle. A write becomes visible after the edge that takes it. Offsets 0 and 1 read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| host_addr_i | input | 3 | Host byte offset |
| host_wr_i | input | 1 | Host write strobe |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Host read data for `host_addr_i` |
| irq_i | input | 1 | Interrupt-logic level |
| start_i | input | 1 | Start bus-master control level |
| fw_err_set_i | input | 1 | Firmware strobe that sets the error flag |
| fw_act_clr_i | input | 1 | Firmware strobe that clears the active flag |
| simplex_cfg_i | input | 1 | Static simplex-capability strap |

## Verification
Read data has zero latency: it follows the offset and the stored state in the same cycle, while the strap reaches bit 7 directly. Every write, firmware strobe and input edge changes stored state at the next rising edge, so it first appears in readback on the cycle after the one that drove it. The bench drives one set of inputs per cycle at the falling edge and checks the read data 1 ns later against a model that has not yet taken that cycle's inputs. It then updates the model at the rising edge, so each effect is compared exactly one edge after its stimulus.

// File: rtl/bm_regs_pkg.sv
package bm_regs_pkg;

    // Status bits that hold state; bit 7 is a strap and bits 4:3 are constant.
    typedef struct packed {
        logic drv1_dma;
        logic drv0_dma;
        logic irq_flag;
        logic err_flag;
        logic act_flag;
    } status_t;

    localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/bm_edge_det.sv
module bm_edge_det #(
    parameter int unsigned W = 1
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] sig_i,
    output logic [W-1:0] rise_o
);

    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = sig_i;
        rise_o = sig_i & ~prev_q;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) prev_q <= '0;
        else         prev_q <= prev_d;
    end

endmodule

// File: rtl/bm_status_bits.sv
module bm_status_bits
    import bm_regs_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        wr_i,
    input  logic [7:0]  wdata_i,
    input  logic        irq_rise_i,
    input  logic        start_rise_i,
    input  logic        fw_err_set_i,
    input  logic        fw_act_clr_i,
    output status_t     stat_o
);

    status_t stat_d, stat_q;
    logic [7:0] clr_mask;

    always_comb begin
        clr_mask = wr_i ? wdata_i : 8'h00;
        stat_d   = stat_q;
        if (wr_i) begin
            stat_d.drv1_dma = wdata_i[6];
            stat_d.drv0_dma = wdata_i[5];
        end
        // set sources override clears in the same cycle
        stat_d.irq_flag = irq_rise_i   | (stat_q.irq_flag & ~clr_mask[2]);
        stat_d.err_flag = fw_err_set_i | (stat_q.err_flag & ~clr_mask[1]);
        stat_d.act_flag = start_rise_i | (stat_q.act_flag & ~fw_act_clr_i);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) stat_q <= '0;
        else         stat_q <= stat_d;
    end

    assign stat_o = stat_q;

endmodule

// File: rtl/bm_byte_bank.sv
module bm_byte_bank #(
    parameter int unsigned NUM_BYTES = 4,
    parameter int unsigned AW        = 3,
    parameter int unsigned BASE      = 4
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          wr_i,
    input  logic [AW-1:0]                 addr_i,
    input  logic [7:0]                    wdata_i,
    output logic [NUM_BYTES-1:0][7:0]     bytes_o
);

    logic [NUM_BYTES-1:0][7:0] bank_d, bank_q;
    logic [NUM_BYTES-1:0]      hit;

    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_hit
        assign hit[g] = wr_i && (addr_i == AW'(BASE + g));
    end

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < NUM_BYTES; i++) begin
            if (hit[i]) bank_d[i] = wdata_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) bank_q <= '0;
        else         bank_q <= bank_d;
    end

    assign bytes_o = bank_q;

endmodule

// File: rtl/dma_status_regs.sv
module dma_status_regs
    import bm_regs_pkg::*;
#(
    parameter int unsigned AW        = 3,
    parameter int unsigned STAT_OFS  = 2,
    parameter int unsigned DEV_OFS   = 3,
    parameter int unsigned PTR_OFS   = 4,
    parameter int unsigned PTR_BYTES = 4
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [AW-1:0] host_addr_i,
    input  logic          host_wr_i,
    input  logic [7:0]    host_wdata_i,
    output logic [7:0]    host_rdata_o,
    input  logic          irq_i,
    input  logic          start_i,
    input  logic          fw_err_set_i,
    input  logic          fw_act_clr_i,
    input  logic          simplex_cfg_i
);

    localparam logic [AW-1:0] STAT_A = AW'(STAT_OFS);
    localparam logic [AW-1:0] DEV_A  = AW'(DEV_OFS);

    logic [1:0]                rise;
    logic                      stat_wr;
    status_t                   stat;
    logic [0:0][7:0]           dev_byte;
    logic [PTR_BYTES-1:0][7:0] ptr_bytes;

    bm_edge_det #(.W(2)) i_edges (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .sig_i  ({start_i, irq_i}),
        .rise_o (rise)
    );

    assign stat_wr = host_wr_i && (host_addr_i == STAT_A);

    bm_status_bits i_status (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .wr_i         (stat_wr),
        .wdata_i      (host_wdata_i),
        .irq_rise_i   (rise[0]),
        .start_rise_i (rise[1]),
        .fw_err_set_i (fw_err_set_i),
        .fw_act_clr_i (fw_act_clr_i),
        .stat_o       (stat)
    );

    bm_byte_bank #(.NUM_BYTES(1), .AW(AW), .BASE(DEV_OFS)) i_dev (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (host_wr_i),
        .addr_i  (host_addr_i),
        .wdata_i (host_wdata_i),
        .bytes_o (dev_byte)
    );

    bm_byte_bank #(.NUM_BYTES(PTR_BYTES), .AW(AW), .BASE(PTR_OFS)) i_ptr (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (host_wr_i),
        .addr_i  (host_addr_i),
        .wdata_i (host_wdata_i),
        .bytes_o (ptr_bytes)
    );

    always_comb begin
        host_rdata_o = 8'h00;
        if (host_addr_i == STAT_A) begin
            host_rdata_o = {simplex_cfg_i, stat.drv1_dma, stat.drv0_dma, 2'b00,
                            stat.irq_flag, stat.err_flag, stat.act_flag};
        end else if (host_addr_i == DEV_A) begin
            host_rdata_o = dev_byte[0];
        end
        for (int i = 0; i < PTR_BYTES; i++) begin
            if (host_addr_i == AW'(PTR_OFS + i)) host_rdata_o = ptr_bytes[i];
        end
    end

endmodule

// File: rtl/bm_status_chk.sv
module bm_status_chk
    import bm_regs_pkg::*;
#(
    parameter int unsigned AW    = 3,
    parameter int unsigned PTR_W = 32
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [AW-1:0]    host_addr_i,
    input logic             host_wr_i,
    input logic [7:0]       host_rdata_o,
    input logic             irq_i,
    input logic             start_i,
    input logic             fw_err_set_i,
    input logic             fw_act_clr_i,
    input logic             simplex_cfg_i,
    input status_t          stat_i,
    input logic [PTR_W-1:0] ptr_i
);

    p_simplex_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (host_addr_i == AW'(2)) |-> (host_rdata_o[7] == simplex_cfg_i));

    p_rsvd_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (host_addr_i == AW'(2)) |-> (host_rdata_o[4:3] == 2'b00));

    p_irq_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_i) |=> stat_i.irq_flag);

    p_err_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fw_err_set_i |=> stat_i.err_flag);

    p_act_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(start_i) |=> stat_i.act_flag);

    p_act_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stat_i.act_flag && !fw_act_clr_i) |=> stat_i.act_flag);

    p_ptr_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !host_wr_i |=> $stable(ptr_i));

endmodule

bind dma_status_regs bm_status_chk #(.AW(AW), .PTR_W(PTR_BYTES * 8)) i_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .host_addr_i   (host_addr_i),
    .host_wr_i     (host_wr_i),
    .host_rdata_o  (host_rdata_o),
    .irq_i         (irq_i),
    .start_i       (start_i),
    .fw_err_set_i  (fw_err_set_i),
    .fw_act_clr_i  (fw_act_clr_i),
    .simplex_cfg_i (simplex_cfg_i),
    .stat_i        (stat),
    .ptr_i         (ptr_bytes)
);

// File: tb/test_dma_status_regs.sv
module test_dma_status_regs;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       wr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq = 1'b0;
    logic       start = 1'b0;
    logic       eset = 1'b0;
    logic       aclr = 1'b0;
    logic       strap = 1'b1;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // bench model
    logic m_d1, m_d0, m_int, m_err, m_act, m_irq_prev, m_start_prev;
    logic [7:0] m_dev;
    logic [7:0] m_ptr [4];

    always #2 clk = ~clk;

    dma_status_regs i_dma_status_regs (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .host_addr_i   (addr),
        .host_wr_i     (wr),
        .host_wdata_i  (wdata),
        .host_rdata_o  (rdata),
        .irq_i         (irq),
        .start_i       (start),
        .fw_err_set_i  (eset),
        .fw_act_clr_i  (aclr),
        .simplex_cfg_i (strap)
    );

    function automatic logic [7:0] exp_read(input logic [2:0] a);
        case (a)
            3'd2:    return {strap, m_d1, m_d0, 2'b00, m_int, m_err, m_act};
            3'd3:    return m_dev;
            3'd4, 3'd5, 3'd6, 3'd7: return m_ptr[a - 3'd4];
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_reset();
        {m_d1, m_d0, m_int, m_err, m_act, m_irq_prev, m_start_prev} = '0;
        m_dev = 8'h00;
        for (int i = 0; i < 4; i++) m_ptr[i] = 8'h00;
    endtask

    task automatic model_update();
        logic ir, sr;
        logic [7:0] w1c;
        ir  = irq & ~m_irq_prev;
        sr  = start & ~m_start_prev;
        w1c = (wr && addr == 3'd2) ? wdata : 8'h00;
        m_int = ir   | (m_int & ~w1c[2]);
        m_err = eset | (m_err & ~w1c[1]);
        m_act = sr   | (m_act & ~aclr);
        if (wr && addr == 3'd2) begin
            m_d1 = wdata[6];
            m_d0 = wdata[5];
        end
        if (wr && addr == 3'd3) m_dev = wdata;
        if (wr && addr >= 3'd4) m_ptr[addr - 3'd4] = wdata;
        m_irq_prev   = irq;
        m_start_prev = start;
    endtask

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: addr %0d read %02h expected %02h", tag, addr, act, exp);
        end
    endtask

    // one cycle: drive at falling edge, check readback, model takes the edge
    task automatic step(input logic [2:0] a, input logic w, input logic [7:0] wd,
                        input logic ir, input logic st, input logic es,
                        input logic ac, input string tag);
        addr = a; wr = w; wdata = wd; irq = ir; start = st; eset = es; aclr = ac;
        #1;
        check(rdata, exp_read(a), tag);
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic rd(input logic [2:0] a, input string tag);
        step(a, 1'b0, 8'h00, irq, start, 1'b0, 1'b0, tag);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        addr = 3'd2; #1;
        check(rdata, 8'h80, "R1");
        for (int a = 0; a < 8; a++) rd(3'(a), "R1");

        // R2: strap drives bit 7, writes ignored
        step(3'd2, 1'b1, 8'h00, 0, 0, 0, 0, "R2");
        rd(3'd2, "R2");
        strap = 1'b0;
        step(3'd2, 1'b1, 8'h80, 0, 0, 0, 0, "R2");
        rd(3'd2, "R2");
        strap = 1'b1;

        // R3: drive flags plain rw, reserved bits zero
        step(3'd2, 1'b1, 8'h78, 0, 0, 0, 0, "R3");
        rd(3'd2, "R3");
        step(3'd2, 1'b1, 8'h18, 0, 0, 0, 0, "R3");
        rd(3'd2, "R3");

        // R4: edge set once, w1c, set beats clear
        step(3'd2, 1'b0, 8'h00, 1, 0, 0, 0, "R4");
        rd(3'd2, "R4");
        step(3'd2, 1'b1, 8'h04, 1, 0, 0, 0, "R4");
        rd(3'd2, "R4");
        rd(3'd2, "R4");
        step(3'd2, 1'b0, 8'h00, 0, 0, 0, 0, "R4");
        step(3'd2, 1'b1, 8'h04, 1, 0, 0, 0, "R4");
        rd(3'd2, "R4");
        step(3'd2, 1'b1, 8'h04, 0, 0, 0, 0, "R4");
        rd(3'd2, "R4");

        // R5: firmware set, host w1c, set beats clear
        step(3'd2, 1'b0, 8'h00, 0, 0, 1, 0, "R5");
        rd(3'd2, "R5");
        step(3'd2, 1'b1, 8'h02, 0, 0, 1, 0, "R5");
        rd(3'd2, "R5");
        step(3'd2, 1'b1, 8'h02, 0, 0, 0, 0, "R5");
        rd(3'd2, "R5");

        // R6: start edge sets, host cannot clear, firmware clears, set wins
        step(3'd2, 1'b0, 8'h00, 0, 1, 0, 0, "R6");
        step(3'd2, 1'b1, 8'hFF, 0, 1, 0, 0, "R6");
        step(3'd2, 1'b1, 8'h01, 0, 0, 0, 0, "R6");
        rd(3'd2, "R6");
        step(3'd2, 1'b0, 8'h00, 0, 0, 0, 1, "R6");
        rd(3'd2, "R6");
        step(3'd2, 1'b0, 8'h00, 0, 1, 0, 1, "R6");
        rd(3'd2, "R6");
        step(3'd2, 1'b0, 8'h00, 0, 0, 0, 1, "R6");
        rd(3'd2, "R6");

        // R7: device byte
        step(3'd3, 1'b1, 8'hA5, 0, 0, 0, 0, "R7");
        rd(3'd3, "R7");
        rd(3'd2, "R7");

        // R8: pointer bytes, low byte at offset 4
        for (int i = 0; i < 4; i++) step(3'(4 + i), 1'b1, 8'(8'h11 * (i + 1)), 0, 0, 0, 0, "R8");
        for (int i = 0; i < 4; i++) rd(3'(4 + i), "R8");

        // R9: unmapped offsets read zero, ignore writes
        step(3'd0, 1'b1, 8'hFF, 0, 0, 0, 0, "R9");
        step(3'd1, 1'b1, 8'hFF, 0, 0, 0, 0, "R9");
        rd(3'd0, "R9");
        rd(3'd1, "R9");
        rd(3'd3, "R9");

        // random mix
        for (int n = 0; n < 4000; n++) begin
            logic [2:0] a;
            logic       ir_n, st_n;
            string      tg;
            a    = 3'($urandom % 8);
            ir_n = (($urandom % 4) == 0) ? ~irq : irq;
            st_n = (($urandom % 5) == 0) ? ~start : start;
            if (n == 2000) strap = 1'b0;
            if (a == 3'd2)      tg = "R4 R5 R6 status";
            else if (a == 3'd3) tg = "R7";
            else if (a >= 3'd4) tg = "R8";
            else                tg = "R9";
            step(a, 1'($urandom % 2), 8'($urandom), ir_n, st_n,
                 (($urandom % 8) == 0), (($urandom % 8) == 0), tg);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule